// File: doc/BRIEF.md
# SCSI Block Transfer Counter Wrapper

This block sits between a host and a SCSI bus controller core. It counts bytes moved through the data port and groups them into 128-byte blocks. It holds an 8-bit block counter and a control/status byte that the host reads and writes. Each time a block completes, it sets two sticky flags that feed the core's status registers. It also sends the core a one-cycle pulse to raise its interrupt.

The interrupt request seen by the host is gated. It passes only when four conditions hold together:
- the core has an interrupt pending,
- the core's interrupt enable is set,
- gate bit 4 of the control/status byte is set,
- no block is part-way through.

Data bytes pass straight between the host data port and the core; the wrapper only counts them. The flag logic is a two-state machine:
- `FLG_IDLE` means no block has ended since the last acknowledge.
- The transition *block end* (128th byte) moves `FLG_IDLE` or `FLG_HELD` to `FLG_HELD`.
- The transition *acknowledge* (the core's interrupt-clearing status read) moves `FLG_HELD` back to `FLG_IDLE`.
- *Block end* wins over *acknowledge* when both occur in the same cycle.

Top module: `scsi_blkcnt_wrap`

## Requirements
- R1: After reset, control/status reads 0x80, the block count reads 0x00, the byte position is 0, both flags are low, `blk_done` is low.
- R2: Each cycle with `dp_strobe` high advances the byte position by one. On the 128th byte the position returns to 0 and the block count becomes (count - 1) mod 256, so 256 and 0 both step to 255.
- R3: A block end sets `end_dma_flag`, `last_byte_flag` and a one-cycle `blk_done` pulse. All three are registered and visible in the cycle after the clock edge that took the 128th byte.
- R4: A register write with `reg_sel`=1 loads the block count with `reg_wdata`. A value of 0 loads 256. The write also clears the byte position.
- R5: With `reg_sel`=1, `reg_rdata` returns the low 8 bits of the block count, so a count of 256 reads 0x00.
- R6: A write with `reg_sel`=0 and `reg_wdata[7]`=1 is a wrapper reset. Control/status becomes 0x80 and the block count becomes 0. The byte position and both flags are left as they were.
- R7: A write with `reg_sel`=0 and `reg_wdata[7]`=0 stores the byte, and `reg_rdata` with `reg_sel`=0 returns it unchanged.
- R8: `irq` = `core_irq` AND `core_irq_en` AND control/status bit 4 AND (byte position = 0).
- R9: Both flags stay high until a cycle with `core_clr_rd` high. If a block end falls in the same cycle as that read, the flags stay set.
- R10: If a block-count write and `dp_strobe` fall in the same cycle, the write takes effect and the strobe is not counted, so no block end can occur.
- R11: `core_wdata` follows `dp_wdata` and `dp_rdata` follows `core_rdata` with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 = control/status, 1 = block count |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the selected register |
| dp_strobe | input | 1 | One data-port byte moved this cycle (read or write) |
| dp_wdata | input | 8 | Host data byte toward the core |
| core_wdata | output | 8 | Data byte passed to the core |
| core_rdata | input | 8 | Data byte from the core |
| dp_rdata | output | 8 | Data byte passed to the host |
| core_irq | input | 1 | Core interrupt pending |
| core_irq_en | input | 1 | Core interrupt enable |
| core_clr_rd | input | 1 | Core's interrupt-clearing status read happened |
| end_dma_flag | output | 1 | Sticky end-of-DMA flag toward the core status |
| last_byte_flag | output | 1 | Sticky last-byte flag toward the core mode register |
| blk_done | output | 1 | One-cycle pulse asking the core to raise its interrupt |
| irq | output | 1 | Gated interrupt request |

## Verification
The assertions check four properties on every cycle:
- the interrupt gating terms;
- that the flags drop only after an acknowledge;
- that each block-end pulse coincides with both flags set and a one-step count decrement;
- the register effects of both reset writes and count writes.

Other behaviour shows only in the bench scenarios. These cover the exact byte on which a block ends over multi-block runs, the 256-load and wrap-through-zero cases, and the write-versus-strobe collision. The collision is followed by a further 128 bytes to show the byte position really restarted.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_HELD = 1'b1
    } flg_state_e;

    localparam int unsigned CSR_RST_BIT  = 7;
    localparam int unsigned CSR_GATE_BIT = 4;
endpackage

// File: rtl/sbc_byte_ctr.sv
module sbc_byte_ctr #(
    parameter int unsigned BLK_BYTES = 128,
    localparam int unsigned BW = $clog2(BLK_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          clear,
    output logic [BW-1:0] pos,
    output logic          wrap,
    output logic          at_zero
);
    localparam logic [BW-1:0] LAST = BW'(BLK_BYTES - 1);

    // clear (block-count write) has priority over a strobe
    assign wrap    = strobe && !clear && (pos == LAST);
    assign at_zero = (pos == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (clear) begin
            pos <= '0;
        end else if (strobe) begin
            pos <= wrap ? '0 : pos + 1'b1;
        end
    end
endmodule

// File: rtl/sbc_blk_ctr.sv
module sbc_blk_ctr #(
    parameter int unsigned CNT_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [CNT_W-1:0] load_val,
    input  logic           zap,
    input  logic           dec,
    output logic [CNT_W:0] cnt
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

    logic [CNT_W-1:0] low_dec;
    assign low_dec = cnt[CNT_W-1:0] - 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n || zap) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= (load_val == '0) ? FULL : {1'b0, load_val};
        end else if (dec) begin
            cnt <= {1'b0, low_dec};
        end
    end
endmodule

// File: rtl/sbc_flag_fsm.sv
module sbc_flag_fsm
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic ack,
    output logic end_dma,
    output logic last_byte,
    output logic done_pulse
);
    flg_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLG_IDLE: if (set) state_d = FLG_HELD;
            FLG_HELD: if (!set && ack) state_d = FLG_IDLE;
            default:  state_d = FLG_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= FLG_IDLE;
            done_pulse <= 1'b0;
        end else begin
            state_q    <= state_d;
            done_pulse <= set;
        end
    end

    always_comb begin
        end_dma   = (state_q == FLG_HELD);
        last_byte = (state_q == FLG_HELD);
    end
endmodule

// File: rtl/scsi_blkcnt_wrap.sv
module scsi_blkcnt_wrap
    import sbc_pkg::*;
#(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned BLK_BYTES = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              dp_strobe,
    input  logic [DATA_W-1:0] dp_wdata,
    output logic [DATA_W-1:0] core_wdata,
    input  logic [DATA_W-1:0] core_rdata,
    output logic [DATA_W-1:0] dp_rdata,
    input  logic              core_irq,
    input  logic              core_irq_en,
    input  logic              core_clr_rd,
    output logic              end_dma_flag,
    output logic              last_byte_flag,
    output logic              blk_done,
    output logic              irq
);
    localparam int unsigned     BW      = $clog2(BLK_BYTES);
    localparam logic [DATA_W-1:0] CSR_INIT = DATA_W'(1) << CSR_RST_BIT;

    logic [DATA_W-1:0] csr_q;
    logic [DATA_W:0]   blk_cnt;
    logic [BW-1:0]     byte_pos;
    logic              byte_zero;
    logic              blk_wrap;
    logic              csr_wr, cnt_wr, wrap_rst;

    assign csr_wr   = reg_wr && !reg_sel;
    assign cnt_wr   = reg_wr &&  reg_sel;
    assign wrap_rst = csr_wr && reg_wdata[CSR_RST_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n || wrap_rst) begin
            csr_q <= CSR_INIT;
        end else if (csr_wr) begin
            csr_q <= reg_wdata;
        end
    end

    sbc_byte_ctr #(.BLK_BYTES(BLK_BYTES)) u_byte (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (dp_strobe),
        .clear   (cnt_wr),
        .pos     (byte_pos),
        .wrap    (blk_wrap),
        .at_zero (byte_zero)
    );

    sbc_blk_ctr #(.CNT_W(DATA_W)) u_blk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_wr),
        .load_val (reg_wdata),
        .zap      (wrap_rst),
        .dec      (blk_wrap),
        .cnt      (blk_cnt)
    );

    sbc_flag_fsm u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (blk_wrap),
        .ack        (core_clr_rd),
        .end_dma    (end_dma_flag),
        .last_byte  (last_byte_flag),
        .done_pulse (blk_done)
    );

    assign reg_rdata  = reg_sel ? blk_cnt[DATA_W-1:0] : csr_q;
    assign core_wdata = dp_wdata;
    assign dp_rdata   = core_rdata;
    assign irq        = core_irq && core_irq_en && csr_q[CSR_GATE_BIT] && byte_zero;
endmodule

// File: rtl/sbc_wrap_chk.sv
module sbc_wrap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_sel,
    input logic [7:0] reg_wdata,
    input logic [7:0] csr_q,
    input logic [8:0] blk_cnt,
    input logic       byte_zero,
    input logic       core_irq,
    input logic       core_irq_en,
    input logic       core_clr_rd,
    input logic       end_dma_flag,
    input logic       last_byte_flag,
    input logic       blk_done,
    input logic       irq
);
    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (core_irq && core_irq_en && csr_q[4] && byte_zero));

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(end_dma_flag) |-> $past(core_clr_rd));

    // R3
    done_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        blk_done |-> (end_dma_flag && last_byte_flag));

    // R2
    blk_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_done && !$past(reg_wr)) |-> (blk_cnt == {1'b0, 8'($past(blk_cnt[7:0]) - 8'd1)}));

    // R6
    wrap_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_sel && reg_wdata[7]) |=> (csr_q == 8'h80 && blk_cnt == 9'd0));

    // R4
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_sel) |=> (byte_zero && blk_cnt == (($past(reg_wdata) == 8'd0) ? 9'd256 : {1'b0, $past(reg_wdata)})));
endmodule

bind scsi_blkcnt_wrap sbc_wrap_chk chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .reg_wr         (reg_wr),
    .reg_sel        (reg_sel),
    .reg_wdata      (reg_wdata),
    .csr_q          (csr_q),
    .blk_cnt        (blk_cnt),
    .byte_zero      (byte_zero),
    .core_irq       (core_irq),
    .core_irq_en    (core_irq_en),
    .core_clr_rd    (core_clr_rd),
    .end_dma_flag   (end_dma_flag),
    .last_byte_flag (last_byte_flag),
    .blk_done       (blk_done),
    .irq            (irq)
);

// File: tb/scsi_blkcnt_wrap_tb.sv
`timescale 1ns/1ps
module scsi_blkcnt_wrap_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] reg_wdata = 8'h00, reg_rdata;
    logic       dp_strobe = 1'b0;
    logic [7:0] dp_wdata = 8'h00, core_wdata, core_rdata = 8'h00, dp_rdata;
    logic       core_irq = 1'b0, core_irq_en = 1'b0, core_clr_rd = 1'b0;
    logic       end_dma_flag, last_byte_flag, blk_done, irq;

    int checks = 0;
    int errors = 0;
    int pulses = 0;

    always #2 clk = ~clk;

    scsi_blkcnt_wrap dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dp_strobe(dp_strobe),
        .dp_wdata(dp_wdata), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .dp_rdata(dp_rdata), .core_irq(core_irq), .core_irq_en(core_irq_en),
        .core_clr_rd(core_clr_rd), .end_dma_flag(end_dma_flag),
        .last_byte_flag(last_byte_flag), .blk_done(blk_done), .irq(irq)
    );

    always @(negedge clk) if (rst_n && blk_done) pulses++;

    // {load, bytes, expected count, expected flag}
    localparam logic [26:0] VEC [8] = '{
        {8'd3,  10'd128, 8'd2,   1'b1},
        {8'd3,  10'd127, 8'd3,   1'b0},
        {8'd0,  10'd128, 8'd255, 1'b1},
        {8'd1,  10'd256, 8'd255, 1'b1},
        {8'd5,  10'd0,   8'd5,   1'b0},
        {8'd10, 10'd384, 8'd7,   1'b1},
        {8'd0,  10'd0,   8'd0,   1'b0},
        {8'd2,  10'd129, 8'd1,   1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic sel, output int v);
        reg_sel = sel;
        #0.1;
        v = int'(reg_rdata);
    endtask

    task automatic strobe(input int n);
        if (n > 0) begin
            @(negedge clk);
            dp_strobe = 1'b1;
            repeat (n) @(negedge clk);
            dp_strobe = 1'b0;
        end
    endtask

    task automatic ack();
        @(negedge clk);
        core_clr_rd = 1'b1;
        @(negedge clk);
        core_clr_rd = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(1'b0, v); chk("R1 csr", v, 8'h80);
        rd(1'b1, v); chk("R1 count", v, 0);
        chk("R1 flags", {end_dma_flag, last_byte_flag, blk_done}, 0);
        wr(1'b0, 8'h10); core_irq = 1'b1; core_irq_en = 1'b1;
        @(negedge clk);
        chk("R1 byte position zero via irq", irq, 1);
        core_irq = 1'b0;

        // R11 pass-through
        dp_wdata = 8'h5a; core_rdata = 8'ha5; #0.1;
        chk("R11 write path", core_wdata, 8'h5a);
        chk("R11 read path", dp_rdata, 8'ha5);

        // R2 R3 R4 R5 table walk
        foreach (VEC[i]) begin
            int exp_p;
            ack();
            pulses = 0;
            wr(1'b1, VEC[i][26:19]);
            strobe(int'(VEC[i][18:9]));
            @(negedge clk);
            exp_p = int'(VEC[i][18:9]) / 128;
            rd(1'b1, v); chk("R2 R5 count", v, VEC[i][8:1]);
            chk("R3 end flag", end_dma_flag, VEC[i][0]);
            chk("R3 last flag", last_byte_flag, VEC[i][0]);
            chk("R3 pulses", pulses, exp_p);
        end

        // R3 exact timing of the block end
        ack(); wr(1'b1, 8'd4);
        strobe(127);
        chk("R3 no flag at 127", end_dma_flag, 0);
        @(negedge clk); dp_strobe = 1'b1;
        @(negedge clk); dp_strobe = 1'b0;
        chk("R3 flag after 128th", end_dma_flag, 1);
        chk("R3 pulse now", blk_done, 1);
        @(negedge clk);
        chk("R3 pulse one cycle", blk_done, 0);

        // R9 hold and ack
        repeat (5) @(negedge clk);
        chk("R9 held", end_dma_flag & last_byte_flag, 1);
        ack();
        chk("R9 cleared", end_dma_flag | last_byte_flag, 0);

        // R9 set wins over ack in the same cycle
        wr(1'b1, 8'd4); strobe(127);
        @(negedge clk); dp_strobe = 1'b1; core_clr_rd = 1'b1;
        @(negedge clk); dp_strobe = 1'b0; core_clr_rd = 1'b0;
        chk("R9 set beats ack", end_dma_flag, 1);
        ack();

        // R8 gating
        wr(1'b0, 8'h10); core_irq = 1'b1; core_irq_en = 1'b1;
        @(negedge clk); chk("R8 all terms", irq, 1);
        strobe(1); chk("R8 mid block", irq, 0);
        wr(1'b1, 8'd1); chk("R8 after load", irq, 1);
        core_irq_en = 1'b0; #0.1; chk("R8 enable off", irq, 0);
        core_irq_en = 1'b1; wr(1'b0, 8'h00); chk("R8 gate bit off", irq, 0);
        core_irq = 1'b0;

        // R7 readback
        wr(1'b0, 8'h35); rd(1'b0, v); chk("R7 readback", v, 8'h35);

        // R6 wrapper reset keeps flags and byte position
        ack(); wr(1'b1, 8'd6); strobe(128); strobe(3);
        wr(1'b0, 8'h95);
        rd(1'b0, v); chk("R6 csr", v, 8'h80);
        rd(1'b1, v); chk("R6 count", v, 0);
        chk("R6 flags kept", end_dma_flag, 1);
        wr(1'b0, 8'h10); core_irq = 1'b1; core_irq_en = 1'b1;
        @(negedge clk); chk("R6 byte position kept", irq, 0);
        core_irq = 1'b0;

        // R10 collision
        ack(); wr(1'b1, 8'd1); strobe(127);
        pulses = 0;
        @(negedge clk);
        dp_strobe = 1'b1; reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 8'd9;
        @(negedge clk);
        dp_strobe = 1'b0; reg_wr = 1'b0;
        @(negedge clk);
        rd(1'b1, v); chk("R10 count", v, 9);
        chk("R10 no flag", end_dma_flag, 0);
        chk("R10 no pulse", pulses, 0);
        strobe(127); rd(1'b1, v); chk("R10 restart 127", v, 9);
        strobe(1); rd(1'b1, v); chk("R10 restart 128", v, 8);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule